// File: doc/BRIEF.md
# Supervisor Control Register with Guarded Watchdog Select

This block holds the control register of a serial-bus supervisor. A bus front end, which is not part of this block, decodes the wire activity. It presents a start event, a stop event, each received data byte with a one-cycle strobe, and a one-cycle register read request. The block answers every accepted strobe with an acknowledge or a no-acknowledge. A read returns one register byte. A watchdog period select drives a separate watchdog counter.

The two watchdog select bits are persistent. They can change only after two volatile latches are armed in order. A write of 02H arms the write latch. A following write of 06H arms the register latch. A final write of the form 0xy0_0010 then stores xy and starts a timed commit. During the commit the busy flag is high and no byte is acknowledged. A final byte with bit 2 set keeps the register latch armed and changes nothing.

Each write holds exactly one byte and takes effect at its closing stop. A read can be issued between steps of the sequence and leaves the latches as they were. A separate pulse reports an attempted write to a protected region, and it disarms the register latch.

Top module: `sup_ctlreg`

## Requirements
- R1: After reset the write latch and the register latch are clear, busy is low, and wd_sel is WD_DEFAULT. The default is 2'b11, which means the watchdog is disabled. The other encodings are 00 for 1.4 s, 01 for 600 ms and 10 for 200 ms.
- R2: While the write latch is clear and busy is low, a data byte other than 02H gets a no-acknowledge and leaves all state unchanged.
- R3: An acknowledged byte 02H sets the write latch at its stop. An acknowledged byte 00H clears the write latch at its stop. Neither byte raises busy.
- R4: An acknowledged byte 06H sets the register latch at its stop, provided the write latch is set.
- R5: While the register latch is set, an acknowledged byte whose bits 7, 4, 3 and 2 are 0 and whose bit 1 is 1 does three things at its stop. It loads bits 6:5 into wd_sel and clears the register latch. It also holds busy high for exactly COMMIT_CYCLES cycles, beginning in the cycle after the stop.
- R6: While the register latch is set, an acknowledged byte matching 0xy0_0110 leaves wd_sel unchanged and keeps the register latch set.
- R7: A second data byte within one write gets a no-acknowledge. The pending write is then dropped, so its stop changes nothing.
- R8: An accepted byte that is followed by a new start, with no stop between them, is discarded.
- R9: A read request produces rd_valid exactly one cycle later. rd_byte is then {0, wd_sel[1], wd_sel[0], 0, 0, register latch, write latch, 0}, with bit 7 first, and the read changes no latch.
- R10: A protected-write pulse clears the register latch on the next edge.
- R11: While busy is high, every data byte gets a no-acknowledge.
- R12: ack_valid rises exactly one cycle after each rx_valid strobe that arrives in a cycle without a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| rx_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rd_req | input | 1 | Register read request pulse |
| prot_attempt | input | 1 | Attempted write to a protected region |
| ack_valid | output | 1 | Acknowledge response valid |
| ack | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| rd_valid | output | 1 | Read byte valid |
| rd_byte | output | 8 | Register byte |
| busy | output | 1 | Persistent commit in progress |
| wd_sel | output | 2 | Watchdog period select |

## Verification
The bench builds the block with COMMIT_CYCLES set to 8 and keeps the default WD_DEFAULT of 2'b11. The short commit lets the bench measure the busy window cycle by cycle. It also lets the bench place a write inside that window and still run several full unlock and commit sequences. The sequences cover an ordinary commit, the zeroing sequence 02H, 06H, 02H, the hold sequence 02H, 06H, 06H, and reads issued between the steps.

// File: rtl/sup_ctl_pkg.sv
package sup_ctl_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_WEL_SET  = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_WEL_CLR  = 8'h00;
  localparam logic [BYTE_W-1:0] CODE_RWEL_SET = 8'h06;
  // The fixed-zero bits and the two latch bits of a commit or hold byte.
  localparam logic [BYTE_W-1:0] FINAL_MASK    = 8'b1001_1110;
  localparam logic [BYTE_W-1:0] FINAL_COMMIT  = 8'b0000_0010;
  localparam logic [BYTE_W-1:0] FINAL_HOLD    = 8'b0000_0110;

  typedef struct packed {
    logic       wel;
    logic       rwel;
    logic [1:0] wd;
  } ctl_state_t;

  function automatic logic [BYTE_W-1:0] pack_reg(input ctl_state_t s);
    return {1'b0, s.wd[1], s.wd[0], 1'b0, 1'b0, s.rwel, s.wel, 1'b0};
  endfunction
endpackage

// File: rtl/sup_byte_track.sv
module sup_byte_track
  import sup_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              busy_i,
  input  logic              wel_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              apply_o,
  output logic [BYTE_W-1:0] pend_byte_o
);
  logic seen_q;
  logic pend_q;
  logic accept;

  assign accept  = !busy_i && (wel_i || byte_i == CODE_WEL_SET);
  assign apply_o = stop_i && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_byte_o <= '0;
      ack_vld_o   <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      ack_vld_o <= 1'b0;
      if (start_i || stop_i) begin
        seen_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (byte_vld_i) begin
        ack_vld_o <= 1'b1;
        if (seen_q) begin
          ack_o  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          seen_q      <= 1'b1;
          ack_o       <= accept;
          pend_q      <= accept;
          pend_byte_o <= byte_i;
        end
      end
    end
  end

  p_busy_nack_r11: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && busy_i && !start_i && !stop_i) |=> (ack_vld_o && !ack_o));
  p_second_nack_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && seen_q && !start_i && !stop_i) |=> !ack_o);
  p_ack_timing_r12: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !start_i && !stop_i) |=> ack_vld_o);
endmodule

// File: rtl/sup_latch_ctrl.sv
module sup_latch_ctrl
  import sup_ctl_pkg::*;
#(
  parameter logic [1:0] WD_DEFAULT = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              prot_i,
  output ctl_state_t        state_o,
  output logic              load_o
);
  logic is_commit;
  logic is_hold;

  assign is_commit = state_o.rwel && ((byte_i & FINAL_MASK) == FINAL_COMMIT);
  assign is_hold   = state_o.rwel && ((byte_i & FINAL_MASK) == FINAL_HOLD);
  assign load_o    = apply_i && is_commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o.wel  <= 1'b0;
      state_o.rwel <= 1'b0;
      state_o.wd   <= WD_DEFAULT;
    end else begin
      if (apply_i) begin
        if (is_commit) begin
          state_o.wd   <= byte_i[6:5];
          state_o.rwel <= 1'b0;
        end else if (is_hold) begin
          state_o.rwel <= 1'b1;
        end else if (byte_i == CODE_WEL_SET) begin
          state_o.wel <= 1'b1;
        end else if (byte_i == CODE_WEL_CLR) begin
          state_o.wel <= 1'b0;
        end else if (byte_i == CODE_RWEL_SET && state_o.wel) begin
          state_o.rwel <= 1'b1;
        end
      end
      if (prot_i) state_o.rwel <= 1'b0;
    end
  end

  p_rwel_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(state_o.rwel) |-> $past(state_o.wel));
  p_wd_change_disarms_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(state_o.wd) |-> !state_o.rwel);
  p_prot_clears_r10: assert property (@(posedge clk) disable iff (rst)
    prot_i |=> !state_o.rwel);
endmodule

// File: rtl/sup_commit_timer.sv
module sup_commit_timer #(
  parameter int COMMIT_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_busy_from_load_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(load_i));
endmodule

// File: rtl/sup_ctlreg.sv
module sup_ctlreg
  import sup_ctl_pkg::*;
#(
  parameter int         COMMIT_CYCLES = 1000000,
  parameter logic [1:0] WD_DEFAULT    = 2'b11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_start,
  input  logic        bus_stop,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rd_req,
  input  logic        prot_attempt,
  output logic        ack_valid,
  output logic        ack,
  output logic        rd_valid,
  output logic [7:0]  rd_byte,
  output logic        busy,
  output logic [1:0]  wd_sel
);
  ctl_state_t        st;
  logic              apply;
  logic              load;
  logic [BYTE_W-1:0] pend_byte;

  sup_byte_track u_track (
    .clk(clk), .rst(rst), .start_i(bus_start), .stop_i(bus_stop),
    .byte_vld_i(rx_valid), .byte_i(rx_byte), .busy_i(busy), .wel_i(st.wel),
    .ack_vld_o(ack_valid), .ack_o(ack), .apply_o(apply), .pend_byte_o(pend_byte)
  );

  sup_latch_ctrl #(.WD_DEFAULT(WD_DEFAULT)) u_latch (
    .clk(clk), .rst(rst), .apply_i(apply), .byte_i(pend_byte),
    .prot_i(prot_attempt), .state_o(st), .load_o(load)
  );

  sup_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load_i(load), .busy_o(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_byte <= pack_reg(st);
    end
  end

  assign wd_sel = st.wd;

  p_read_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));
  p_read_keeps_latches_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !apply && !prot_attempt) |=> ($stable(st.wel) && $stable(st.rwel)));
endmodule

// File: tb/test_sup_ctlreg.sv
module test_sup_ctlreg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rd_req = 1'b0, prot_attempt = 1'b0;
  logic       ack_valid, ack, rd_valid, busy;
  logic [7:0] rd_byte;
  logic [1:0] wd_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sup_ctlreg #(.COMMIT_CYCLES(8)) i_sup_ctlreg (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
    .prot_attempt(prot_attempt), .ack_valid(ack_valid), .ack(ack),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .busy(busy), .wd_sel(wd_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: bit 8 of an entry marks a read, otherwise bit 0 holds the expected ack.
  always @(negedge clk) begin
    cycles++;
    if (ack_valid || rd_valid) begin
      if (exp_q.size() == 0) begin
        check("unexpected response R12", 1, 0);
      end else begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (e[8]) check(t, rd_valid ? int'(rd_byte) : 'h1ff, int'(e[7:0]));
        else      check(t, ack_valid ? int'(ack) : 2, int'(e[0]));
      end
    end
    if (cycles > 20000) begin
      check("watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_start(); bus_start = 1; tick(); bus_start = 0; endtask
  task automatic pulse_stop();  bus_stop = 1;  tick(); bus_stop = 0;  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    exp_q.push_back({1'b0, 7'd0, exp_ack}); tag_q.push_back(tag);
    rx_byte = b; rx_valid = 1; tick(); rx_valid = 0;
  endtask

  task automatic wr(input logic [7:0] b, input logic exp_ack, input string tag);
    pulse_start(); send_byte(b, exp_ack, tag); pulse_stop();
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back({1'b1, exp}); tag_q.push_back(tag);
    rd_req = 1; tick(); rd_req = 0; tick();
  endtask

  task automatic wait_idle();
    while (busy) tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    check("R1 wd_sel reset", int'(wd_sel), 3);
    check("R1 busy reset", int'(busy), 0);
    rd(8'h60, "R1 reset read");

    wr(8'h06, 1'b0, "R2 nack without wel");
    rd(8'h60, "R2 state unchanged");

    wr(8'h02, 1'b1, "R3 set wel ack");
    check("R3 no busy", int'(busy), 0);
    rd(8'h62, "R3 wel set");
    wr(8'h00, 1'b1, "R3 clr wel ack");
    rd(8'h60, "R3 wel clear");
    wr(8'h02, 1'b1, "R3 set wel again");

    wr(8'h06, 1'b1, "R4 set rwel ack");
    rd(8'h66, "R4 rwel set");
    wr(8'h06, 1'b1, "R6 hold ack");
    rd(8'h66, "R6 rwel kept");
    check("R6 wd unchanged", int'(wd_sel), 3);

    prot_attempt = 1; tick(); prot_attempt = 0;
    rd(8'h62, "R10 rwel cleared");

    wr(8'h06, 1'b1, "R4 rearm");
    wr(8'h42, 1'b1, "R5 commit ack");
    begin
      int n = 0;
      while (busy && n < 100) begin n++; tick(); end
      check("R5 busy length", n, 8);
    end
    tick();
    check("R5 wd_sel committed", int'(wd_sel), 2);
    rd(8'h42, "R5 rwel cleared after commit");

    pulse_start();
    send_byte(8'h00, 1'b1, "R7 first byte ack");
    send_byte(8'h02, 1'b0, "R7 second byte nack");
    pulse_stop();
    rd(8'h42, "R7 aborted write");

    pulse_start();
    send_byte(8'h00, 1'b1, "R8 byte ack");
    pulse_start();
    pulse_stop();
    rd(8'h42, "R8 discarded byte");

    wr(8'h06, 1'b1, "R9 arm");
    rd(8'h46, "R9 read between steps");
    wr(8'h22, 1'b1, "R9 commit after read");
    check("R11 busy up", int'(busy), 1);
    wr(8'h02, 1'b0, "R11 nack while busy");
    wait_idle();
    check("R5 wd 01", int'(wd_sel), 1);
    rd(8'h22, "R11 busy write ignored");

    wr(8'h06, 1'b1, "R5 zero seq arm");
    rd(8'h26, "R5 zero seq armed");
    wr(8'h02, 1'b1, "R5 zero seq commit");
    wait_idle();
    check("R5 wd zeroed", int'(wd_sel), 0);
    rd(8'h02, "R5 zero seq read");

    repeat (3) tick();
    check("R12 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule